// File: doc/BRIEF.md
# Ring-Oscillator Frequency Comparison BIST Controller

This block grades a bank of through-silicon vias before bonding. Each via loads its own ring oscillator. The controller measures the oscillators one after another with a single shared edge counter. For each oscillator it counts rising edges over a fixed window of `GATE_CYCLES` BIST clock cycles and stores the count. From all stored counts it derives the minimum, the maximum and the integer mean. It then marks every via whose count falls outside a band of the mean plus or minus a programmable threshold.

Software starts a run with a one-cycle `start` pulse. At that pulse the block takes a reporting mode and a threshold code, and it raises `busy`. When `done` is high, the `result` port is meant to be captured by a test data register behind the JTAG port. Depending on the mode, `result` holds a pass/fail bit, the number of failing vias, or a serial view of the per-via fail mask that advances with `rd_shift`.

The FSM has seven states:
- IDLE waits for start.
- SETTLE lets the synchronizer flush after the oscillator select changes and holds the counter at zero.
- GATE counts edges for the window.
- STORE saves the count and updates the running sum, minimum and maximum. It then returns to SETTLE for the next index, or moves to REDUCE after the last one.
- REDUCE registers the mean, the threshold and the pass/fail verdict.
- GRADE checks one stored count per cycle against the band.
- REPORT holds the results. A new start in REPORT goes directly to SETTLE.

Top module: `osc_cmp_bist`

## Requirements
- R1: After reset, `busy`, `done` and `result` are 0. A `start` seen while `busy` is low sets `busy` on the next clock edge and clears `done`.
- R2: The oscillators are measured one at a time, in index order 0 to N-1. Each measurement is the number of rising edges of that oscillator, seen through a synchronizer, during `GATE_CYCLES` clock cycles. An oscillator held low reads 0.
- R3: The edge counter saturates at 2^CNT_W-1 and never wraps.
- R4: A threshold code k means k×5 %. Codes 0 and 1 both act as 1, and codes 11 to 15 act as 10. The mean is floor(sum/N), and the threshold in counts is floor(mean×k/20).
- R5: In pass/fail mode (mode 2'b00, and also 2'b11), `result` bit 0 is 1 when max−min ≤ threshold and 0 otherwise. All other `result` bits are 0.
- R6: Oscillator i is faulty when its count is below mean−threshold or above mean+threshold. A count exactly on a band edge passes.
- R7: In count mode (mode 2'b01), `result` is the number of faulty oscillators, from 0 to N.
- R8: In mask mode (mode 2'b10), `result` bit 0 shows the fail bit of the lowest index not yet read out, and the upper bits are 0. Each clock edge with `rd_shift` high while `done` is high moves the mask one index down and fills with 0.
- R9: `done` rises one cycle after the last grading step and is never high together with `busy`. While `done` stays high and `rd_shift` is low, `result` does not change.
- R10: Mode and threshold code are captured only when a run starts. Changes to them, and further `start` pulses while `busy` is high, do not affect the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | BIST clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when the block is not busy |
| mode | input | 2 | Reporting mode: 00 pass/fail, 01 count, 10 mask, 11 pass/fail |
| thr_code | input | 4 | Threshold code k, in steps of 5 % |
| rd_shift | input | 1 | Advances the mask readout by one index |
| osc_in | input | N | Ring oscillator outputs, one per via |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Results are valid |
| result | output | $clog2(N+1) | Verdict, fail count or mask bit, selected by mode |

## Verification
The assertions assume four things about the inputs:
- Every oscillator stays high and low for at least two clock cycles, so the synchronizer sees each edge.
- `rst_n` is released synchronously to the clock.
- `rd_shift` is meaningful only while `done` is high.
- The combinational mean and threshold see a sum that no longer changes once REDUCE is reached.

The bench generates each oscillator by toggling it at falling clock edges every h cycles, with h ≥ 2 or the oscillator held low. Every random configuration whose pass/fail or band decision lies within four counts of the threshold is rejected, so the ±1 count uncertainty from oscillator phase cannot change an expected verdict.

// File: rtl/osc_bist_pkg.sv
package osc_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_GATE   = 3'd2,
        ST_STORE  = 3'd3,
        ST_REDUCE = 3'd4,
        ST_GRADE  = 3'd5,
        ST_REPORT = 3'd6
    } bist_state_e;

    typedef enum logic [1:0] {
        RPT_PASSFAIL = 2'd0,
        RPT_COUNT    = 2'd1,
        RPT_MASK     = 2'd2,
        RPT_SPARE    = 2'd3
    } report_mode_e;

    localparam int unsigned THR_DIVISOR = 20;

    // Out-of-range codes are folded into the legal 1..10 band (R4)
    function automatic logic [3:0] clamp_code(input logic [3:0] c);
        logic [3:0] r;
        r = c;
        if (c < 4'd1) r = 4'd1;
        else if (c > 4'd10) r = 4'd10;
        return r;
    endfunction

endpackage

// File: rtl/osc_probe.sv
module osc_probe #(
    parameter int N           = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     osc_in,
    input  logic [SEL_W-1:0] sel,
    output logic             rise
);

    logic                   picked;
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    assign picked = osc_in[sel];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= 1'b0;
            end else if (s == 0) begin
                chain[s] <= picked;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain[SYNC_STAGES-1];
        end
    end

    assign rise = chain[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] TOP = '1;

    // Holds at the top value instead of wrapping (R3)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && (value != TOP)) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/band_stats.sv
module band_stats
    import osc_bist_pkg::*;
#(
    parameter int N     = 8,
    parameter int CNT_W = 12,
    parameter int SUM_W = 15
) (
    input  logic [SUM_W-1:0] sum,
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] mean,
    output logic [CNT_W-1:0] thr
);

    logic [CNT_W+3:0] prod;

    // Integer mean, then threshold = mean*k*5/100 (R4)
    assign mean = CNT_W'(sum / SUM_W'(N));
    assign prod = {4'b0000, mean} * {{CNT_W{1'b0}}, code};
    assign thr  = CNT_W'(prod / (CNT_W+4)'(THR_DIVISOR));

endmodule

// File: rtl/band_check.sv
module band_check #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] mean,
    input  logic [CNT_W-1:0] thr,
    output logic             outside
);

    logic [CNT_W-1:0] lo;
    logic [CNT_W:0]   hi;

    // thr never exceeds mean/2, so the lower edge cannot underflow
    assign lo      = mean - thr;
    assign hi      = {1'b0, mean} + {1'b0, thr};
    assign outside = (cnt < lo) || ({1'b0, cnt} > hi);

endmodule

// File: rtl/osc_cmp_bist.sv
module osc_cmp_bist
    import osc_bist_pkg::*;
#(
    parameter int N           = 8,
    parameter int CNT_W       = 12,
    parameter int GATE_CYCLES = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int RES_W      = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [3:0]       thr_code,
    input  logic             rd_shift,
    input  logic [N-1:0]     osc_in,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);

    localparam int IDX_W         = (N > 1) ? $clog2(N) : 1;
    localparam int SUM_W         = CNT_W + IDX_W;
    localparam int SETTLE_CYCLES = SYNC_STAGES + 2;
    localparam int TMR_MAX       = (GATE_CYCLES > SETTLE_CYCLES) ? GATE_CYCLES : SETTLE_CYCLES;
    localparam int TMR_W         = $clog2(TMR_MAX);
    localparam logic [IDX_W-1:0] IDX_LAST    = IDX_W'(N - 1);
    localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYCLES - 1);
    localparam logic [TMR_W-1:0] GATE_LAST   = TMR_W'(GATE_CYCLES - 1);

    bist_state_e      state_q, state_d;
    report_mode_e     mode_q;
    logic [3:0]       code_q;
    logic [IDX_W-1:0] idx_q;
    logic [TMR_W-1:0] tmr_q;
    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] min_q, max_q, mean_q, thr_q;
    logic [CNT_W-1:0] mean_c, thr_c;
    logic             pass_q;
    logic [RES_W-1:0] fail_q;
    logic [N-1:0]     mask_q;
    logic [CNT_W-1:0] cnt_mem [N];

    logic             rise;
    logic [CNT_W-1:0] cnt_val;
    logic             outside_c;
    logic             idx_last, settle_last, gate_last, launch;

    assign idx_last    = (idx_q == IDX_LAST);
    assign settle_last = (tmr_q == SETTLE_LAST);
    assign gate_last   = (tmr_q == GATE_LAST);
    assign launch      = start && ((state_q == ST_IDLE) || (state_q == ST_REPORT));

    // Selected oscillator, synchronized and edge-detected (R2)
    osc_probe #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_probe (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_in (osc_in),
        .sel    (idx_q),
        .rise   (rise)
    );

    // The one shared counter (R2, R3)
    sat_counter #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_SETTLE),
        .inc   ((state_q == ST_GATE) && rise),
        .value (cnt_val)
    );

    band_stats #(.N(N), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_stats (
        .sum  (sum_q),
        .code (code_q),
        .mean (mean_c),
        .thr  (thr_c)
    );

    band_check #(.CNT_W(CNT_W)) u_grade (
        .cnt     (cnt_mem[idx_q]),
        .mean    (mean_q),
        .thr     (thr_q),
        .outside (outside_c)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_last) state_d = ST_GATE;
            ST_GATE:   if (gate_last) state_d = ST_STORE;
            ST_STORE:  state_d = idx_last ? ST_REDUCE : ST_SETTLE;
            ST_REDUCE: state_d = ST_GRADE;
            ST_GRADE:  if (idx_last) state_d = ST_REPORT;
            ST_REPORT: if (start) state_d = ST_SETTLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Registered outputs: done appears one cycle after the last grading step (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            busy <= (state_d != ST_IDLE) && (state_d != ST_REPORT);
            done <= (state_d == ST_REPORT);
        end
    end

    // Datapath: sequencing, accumulation and grading
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= RPT_PASSFAIL;
            code_q <= 4'd1;
            idx_q  <= '0;
            tmr_q  <= '0;
            sum_q  <= '0;
            min_q  <= '0;
            max_q  <= '0;
            mean_q <= '0;
            thr_q  <= '0;
            pass_q <= 1'b0;
            fail_q <= '0;
            mask_q <= '0;
        end else if (launch) begin
            // Settings are taken here only (R10)
            mode_q <= report_mode_e'(mode);
            code_q <= clamp_code(thr_code);
            idx_q  <= '0;
            tmr_q  <= '0;
            sum_q  <= '0;
            fail_q <= '0;
            mask_q <= '0;
        end else begin
            case (state_q)
                ST_SETTLE: tmr_q <= settle_last ? '0 : tmr_q + 1'b1;
                ST_GATE:   tmr_q <= gate_last ? '0 : tmr_q + 1'b1;
                ST_STORE: begin
                    sum_q <= sum_q + {{IDX_W{1'b0}}, cnt_val};
                    if (idx_q == '0) begin
                        min_q <= cnt_val;
                        max_q <= cnt_val;
                    end else begin
                        if (cnt_val < min_q) min_q <= cnt_val;
                        if (cnt_val > max_q) max_q <= cnt_val;
                    end
                    idx_q <= idx_last ? '0 : idx_q + 1'b1;
                end
                ST_REDUCE: begin
                    mean_q <= mean_c;
                    thr_q  <= thr_c;
                    pass_q <= ((max_q - min_q) <= thr_c);   // R5
                end
                ST_GRADE: begin
                    mask_q[idx_q] <= outside_c;             // R6
                    fail_q <= fail_q + {{(RES_W-1){1'b0}}, outside_c};
                    idx_q  <= idx_last ? '0 : idx_q + 1'b1;
                end
                ST_REPORT: if (rd_shift) mask_q <= mask_q >> 1;  // R8
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_STORE) cnt_mem[idx_q] <= cnt_val;
    end

    // Report multiplexer
    always_comb begin
        result = '0;
        if (done) begin
            case (mode_q)
                RPT_COUNT: result    = fail_q;
                RPT_MASK:  result[0] = mask_q[0];
                default:   result[0] = pass_q;
            endcase
        end
    end

endmodule

// File: rtl/osc_cmp_bist_chk.sv
module osc_cmp_bist_chk
    import osc_bist_pkg::*;
#(
    parameter int N     = 8,
    parameter int CNT_W = 12,
    parameter int RES_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_shift,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] result,
    input logic [1:0]       mode_q,
    input logic [2:0]       state_q,
    input logic [CNT_W-1:0] cnt_val
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_cnt_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE) |=> ((state_q != ST_GATE) || (cnt_val >= $past(cnt_val))));

    assert_cnt_hold_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_GATE) && (cnt_val == CNT_TOP)) |=> ((state_q != ST_GATE) || (cnt_val == CNT_TOP)));

    assert_pf_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ((mode_q == RPT_PASSFAIL) || (mode_q == RPT_SPARE))) |-> ((result >> 1) == '0));

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == RPT_COUNT)) |-> (result <= RES_W'(N)));

    assert_mask_single_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == RPT_MASK)) |-> ((result >> 1) == '0));

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_done_after_grade_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == ST_GRADE));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_shift && !start) |=> (done && $stable(result)));

    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(mode_q)));

endmodule

bind osc_cmp_bist osc_cmp_bist_chk #(.N(N), .CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_shift (rd_shift),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .mode_q   (mode_q),
    .state_q  (state_q),
    .cnt_val  (cnt_val)
);

// File: tb/osc_cmp_bist_test.sv
module osc_cmp_bist_test;

    localparam int N     = 8;
    localparam int GATE  = 1024;
    localparam int RES_W = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_shift = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [3:0] thr_code = 4'd1;
    wire  [N-1:0] osc, osc_s;
    logic busy, done, busy_s, done_s;
    logic [RES_W-1:0] result, result_s;

    int half [N];
    int half_s [N];
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    osc_cmp_bist #(.N(N), .CNT_W(12), .GATE_CYCLES(GATE), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .thr_code(thr_code),
        .rd_shift(rd_shift), .osc_in(osc), .busy(busy), .done(done), .result(result));

    // Narrow counter copy to expose saturation (R3)
    osc_cmp_bist #(.N(N), .CNT_W(8), .GATE_CYCLES(GATE), .SYNC_STAGES(2)) uut_sat (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .thr_code(thr_code),
        .rd_shift(rd_shift), .osc_in(osc_s), .busy(busy_s), .done(done_s), .result(result_s));

    for (genvar g = 0; g < N; g++) begin : g_osc
        logic o = 1'b0;
        logic os = 1'b0;
        int ph = 0;
        int phs = 0;
        always @(negedge clk) begin
            if (half[g] <= 0) begin o <= 1'b0; ph <= 0; end
            else if (ph >= half[g] - 1) begin o <= ~o; ph <= 0; end
            else ph <= ph + 1;
            if (half_s[g] <= 0) begin os <= 1'b0; phs <= 0; end
            else if (phs >= half_s[g] - 1) begin os <= ~os; phs <= 0; end
            else phs <= phs + 1;
        end
        assign osc[g]   = o;
        assign osc_s[g] = os;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int nominal(input int h, input int cap);
        int c;
        c = (h <= 0) ? 0 : GATE / (2 * h);
        return (c > cap) ? cap : c;
    endfunction

    function automatic int abs_i(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Expected verdicts from R4, R5, R6, R7
    function automatic void model(input int hv[N], input int code, input int cap,
                                  output int pass, output int fcnt, output int mask,
                                  output int margin);
        int c [N];
        int sum, mn, mx, mean, thr, k, dev;
        k = (code < 1) ? 1 : ((code > 10) ? 10 : code);
        sum = 0; mn = 1 << 30; mx = 0;
        for (int i = 0; i < N; i++) begin
            c[i] = nominal(hv[i], cap);
            sum += c[i];
            if (c[i] < mn) mn = c[i];
            if (c[i] > mx) mx = c[i];
        end
        mean = sum / N;
        thr = (mean * k) / 20;
        pass = ((mx - mn) <= thr) ? 1 : 0;
        margin = abs_i((mx - mn) - thr);
        fcnt = 0; mask = 0;
        for (int i = 0; i < N; i++) begin
            dev = abs_i(c[i] - mean);
            if (abs_i(dev - thr) < margin) margin = abs_i(dev - thr);
            if (dev > thr) begin fcnt++; mask |= (1 << i); end
        end
    endfunction

    task automatic launch(input logic [1:0] md, input logic [3:0] code);
        @(negedge clk);
        mode = md; thr_code = code; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 busy after start", busy, 1);
        check("R1 done cleared", done, 0);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic read_mask(input int exp_mask, input string tag);
        for (int b = 0; b < N; b++) begin
            check(tag, result[0], (exp_mask >> b) & 1);
            check("R8 upper bits zero", result >> 1, 0);
            rd_shift = 1'b1;
            @(negedge clk);
            rd_shift = 1'b0;
        end
        check("R8 zero fill", result, 0);
    endtask

    task automatic full_check(input int code, input string tag);
        int p, f, m, mg;
        model(half, code, 4095, p, f, m, mg);
        launch(2'b00, 4'(code)); wait_done();
        check({tag, " R5 pass/fail"}, result, p);
        launch(2'b01, 4'(code)); wait_done();
        check({tag, " R7 R6 fail count"}, result, f);
        launch(2'b10, 4'(code)); wait_done();
        read_mask(m, {tag, " R8 R6 mask bit"});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog: actual no completion, expected done within limit");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int p, f, m, mg, code;
        int hv [N];
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin half[i] = 4; half_s[i] = 2; end
        half_s[N-1] = 3;
        repeat (4) @(negedge clk);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        check("R1 reset result", result, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Equal oscillators: pass and no failures (R2, R5, R7)
        launch(2'b00, 4'd1); wait_done();
        check("R2 R5 equal bank passes", result, 1);
        launch(2'b01, 4'd1); wait_done();
        check("R2 R7 equal bank no failures", result, 0);
        model(half_s, 1, 255, p, f, m, mg);
        check("R3 saturating counter fail count", result_s, f);

        // One stuck oscillator (R2, R5, R6, R7, R8, R9)
        half[3] = 0;
        model(half, 4, 4095, p, f, m, mg);
        launch(2'b00, 4'd4); wait_done();
        check("R5 stuck via fails", result, p);
        launch(2'b01, 4'd4); wait_done();
        check("R2 R7 stuck via count", result, f);
        repeat (5) @(negedge clk);
        check("R9 result held", result, f);
        check("R9 done held", done, 1);
        launch(2'b10, 4'd4); wait_done();
        read_mask(m, "R8 R6 stuck mask bit");

        // Settings frozen and start ignored while busy (R10)
        launch(2'b01, 4'd4);
        repeat (100) @(negedge clk);
        mode = 2'b00; thr_code = 4'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy kept", busy, 1);
        wait_done();
        check("R10 mode and code from launch", result, f);

        // Code clamping (R4)
        half[0] = 5; half[1] = 3; half[3] = 4;
        model(half, 0, 4095, p, f, m, mg);
        launch(2'b01, 4'd0); wait_done();
        check("R4 code 0 acts as 1", result, f);
        half[0] = 4; half[1] = 16;
        model(half, 15, 4095, p, f, m, mg);
        launch(2'b01, 4'd15); wait_done();
        check("R4 code 15 acts as 10", result, f);

        // Constrained random banks with decision margin of at least 4
        for (int t = 0; t < 3; t++) begin
            int tries;
            tries = 0;
            do begin
                int base;
                base = 3 + int'($urandom % 3);
                for (int i = 0; i < N; i++) begin
                    int sel;
                    sel = int'($urandom % 4);
                    if (($urandom % 4) == 0) hv[i] = (sel == 0) ? 0 : ((sel == 1) ? 2 : ((sel == 2) ? 8 : 16));
                    else hv[i] = base;
                end
                code = int'($urandom % 16);
                model(hv, code, 4095, p, f, m, mg);
                tries++;
            end while (mg < 4 && tries < 200);
            for (int i = 0; i < N; i++) half[i] = hv[i];
            full_check(code, "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule